// File: doc/BRIEF.md
# Dual-Slot Edge Input Capture

This block watches a timer pin that has already been brought into the clock domain. On each selected edge it copies the running counter value into one of two capture registers. The first qualifying edge fills the first register and the second fills the second. After that the block ignores edges until its slot count is cleared.

A single-cycle event strobe reports a capture. A select bit chooses whether the strobe follows the first capture or the second. Software clears the slot count in one of two ways: by writing the status register with the capture bit set, or by switching the capture mode from off to an active mode.

Counter generation, interrupt masking and input synchronizers belong to the surrounding timer.

Top module: `edge_capture_unit`

## Requirements
- R1: `cap_mode` selects the qualifying edge: 0 = none, 1 = rising (0 to 1), 2 = falling (1 to 0), 3 = either edge. With mode 0 no capture and no event ever occur.
- R2: Captures happen only while `pin_is_input` is 1. With it at 0, edges change neither register and raise no event.
- R3: A qualifying edge with slot count 0 stores `counter_in` into `cap_first`, and one with count 1 stores it into `cap_second`. The stored value is the one present in the same cycle as the new pin level. At count 2 further edges change nothing; the count never exceeds 2.
- R4: `cap_event` is high for exactly one cycle, in the cycle after the capturing clock edge. It is raised only for the first capture when `cnt_sel` is 0, or only for the second capture when `cnt_sel` is 1. `cnt_sel` is sampled together with the edge.
- R5: A one-cycle `stat_clr_cap` pulse returns the slot count to 0. It leaves both capture registers unchanged.
- R6: Two conditions together return the slot count to 0: `ctrl_wr` is high in the first cycle a new mode is shown, and the mode seen in the previous cycle was 0 while the new one is non-zero. A control write that keeps the mode active leaves the count unchanged.
- R7: After a synchronous active-low reset, both capture registers read 0, the slot count is 0, and `cap_event` is 0.
- R8: Edges are found by comparing `pin_in` with its value one cycle earlier. That stored value updates every cycle, including while capture is off or the pin is an output, and resets to 0.
- R9: When a clear (R5 or R6) coincides with a qualifying edge, the clear wins. The edge is not captured and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Synchronized timer pin level |
| counter_in | input | CNT_W | Running counter value |
| cap_mode | input | 2 | Edge select: off, rising, falling, both |
| cnt_sel | input | 1 | 0: event on first capture, 1: event on second |
| pin_is_input | input | 1 | 1 when the pin is configured as an input |
| stat_clr_cap | input | 1 | Status write with the capture bit set |
| ctrl_wr | input | 1 | Control register write strobe |
| cap_first | output | CNT_W | First capture register |
| cap_second | output | CNT_W | Second capture register |
| cap_event | output | 1 | One-cycle capture event strobe |

## Verification
The assertions assume the following about the inputs:
- `stat_clr_cap` and `ctrl_wr` are single-cycle strobes.
- `ctrl_wr` coincides with the first cycle in which the new mode is visible.
- All control inputs are stable for a whole cycle.

The stimulus changes every input just after a rising clock edge, holds each control setting for the whole cycle, and raises each strobe for exactly one step. The sweep covers every combination of mode, direction and count select, with more edges than there are slots.

// File: rtl/ecap_pkg.sv
// Shared definitions for the dual-slot edge capture block.
// Assumes two capture slots; the slot count width is derived from that.
package ecap_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE    = 2'd0,
        EDGE_RISE    = 2'd1,
        EDGE_FALL    = 2'd2,
        EDGE_EITHER  = 2'd3
    } edge_sel_e;

    localparam int NUM_SLOTS = 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
endpackage

// File: rtl/ecap_edge_det.sv
// Edge detector: compares the pin with its value one cycle earlier and
// reports a hit for the edge kind chosen by the mode.
// Assumes pin is already synchronized; the history updates every cycle.
module ecap_edge_det
    import ecap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  logic [1:0] mode,
    output logic      hit
);
    logic pin_q;

    // Hold last cycle's pin level, regardless of mode.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    // Select the qualifying edge kind.
    always_comb begin
        unique case (edge_sel_e'(mode))
            EDGE_RISE:   hit = pin & ~pin_q;
            EDGE_FALL:   hit = ~pin & pin_q;
            EDGE_EITHER: hit = pin ^ pin_q;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ecap_slot_ctrl.sv
// Slot controller: keeps the saturating slot count, decides which capture
// register is written, applies the two clear sources and forms the event.
// Assumes ctrl_wr coincides with the first cycle the new mode is visible.
module ecap_slot_ctrl
    import ecap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic                 pin_is_input,
    input  logic [1:0]           mode,
    input  logic                 cnt_sel,
    input  logic                 stat_clr_cap,
    input  logic                 ctrl_wr,
    output logic [NUM_SLOTS-1:0] slot_we,
    output logic [SLOT_W-1:0]    slot_cnt,
    output logic                 evt
);
    logic [1:0] mode_q;
    logic       arm_clr;
    logic       clr_any;
    logic       take;

    // Clear sources and capture qualification.
    always_comb begin
        arm_clr = ctrl_wr && (mode_q == EDGE_NONE) && (mode != EDGE_NONE);
        clr_any = stat_clr_cap | arm_clr;
        take    = hit & pin_is_input & ~clr_any &
                  (slot_cnt < SLOT_W'(NUM_SLOTS));
    end

    // One write enable per slot, chosen by the current count.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_we
        assign slot_we[i] = take && (slot_cnt == SLOT_W'(i));
    end

    // Count, event and previous-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            evt      <= 1'b0;
            mode_q   <= EDGE_NONE;
        end else begin
            mode_q <= mode;
            evt    <= take && (slot_cnt == SLOT_W'(cnt_sel));
            if (clr_any)   slot_cnt <= '0;
            else if (take) slot_cnt <= slot_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ecap_bank.sv
// Capture register bank: one register per slot, loaded from the counter
// when its write enable is high. Assumes at most one enable per cycle.
module ecap_bank
    import ecap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SLOTS-1:0]            we,
    input  logic [CNT_W-1:0]                din,
    output logic [NUM_SLOTS-1:0][CNT_W-1:0] q
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Load this slot's register on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[i] <= '0;
            else if (we[i]) q[i] <= din;
        end
    end
endmodule

// File: rtl/edge_capture_unit.sv
// Dual-slot edge input capture: latches the counter into two registers on
// selected pin edges and strobes an event after the first or second one.
// Assumes a synchronized pin and single-cycle write strobes.
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] counter_in,
    input  logic [1:0]       cap_mode,
    input  logic             cnt_sel,
    input  logic             pin_is_input,
    input  logic             stat_clr_cap,
    input  logic             ctrl_wr,
    output logic [CNT_W-1:0] cap_first,
    output logic [CNT_W-1:0] cap_second,
    output logic             cap_event
);
    logic                            hit;
    logic [NUM_SLOTS-1:0]            slot_we;
    logic [SLOT_W-1:0]               slot_cnt;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] regs;

    ecap_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .pin(pin_in), .mode(cap_mode), .hit(hit)
    );

    ecap_slot_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .hit(hit), .pin_is_input(pin_is_input),
        .mode(cap_mode), .cnt_sel(cnt_sel), .stat_clr_cap(stat_clr_cap),
        .ctrl_wr(ctrl_wr), .slot_we(slot_we), .slot_cnt(slot_cnt),
        .evt(cap_event)
    );

    ecap_bank #(.CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(slot_we), .din(counter_in), .q(regs)
    );

    assign cap_first  = regs[0];
    assign cap_second = regs[1];
endmodule

// File: rtl/ecap_checker.sv
// Property checker for edge_capture_unit, attached by bind below.
module ecap_checker
    import ecap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin_is_input,
    input logic [1:0]        cap_mode,
    input logic              cnt_sel,
    input logic              stat_clr_cap,
    input logic              cap_event,
    input logic [SLOT_W-1:0] slot_cnt,
    input logic [CNT_W-1:0]  cap_first,
    input logic [CNT_W-1:0]  cap_second
);
    assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cnt <= SLOT_W'(NUM_SLOTS));

    assert_first_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cnt != 0) |=> $stable(cap_first));

    assert_second_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cnt != 1) |=> $stable(cap_second));

    assert_dir_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> $past(pin_is_input));

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> ($past(cap_mode) != 2'd0));

    assert_evt_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> (($past(slot_cnt) == SLOT_W'($past(cnt_sel))) &&
                       (slot_cnt == $past(slot_cnt) + 1'b1)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_cap |=> (slot_cnt == 0));

    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_cap |=> !cap_event);
endmodule

bind edge_capture_unit ecap_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pin_is_input(pin_is_input),
    .cap_mode(cap_mode), .cnt_sel(cnt_sel), .stat_clr_cap(stat_clr_cap),
    .cap_event(cap_event), .slot_cnt(slot_cnt), .cap_first(cap_first),
    .cap_second(cap_second)
);

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_in = 1'b0;
    logic [CNT_W-1:0] counter_in = '0;
    logic [1:0]       cap_mode = 2'd0;
    logic             cnt_sel = 1'b0;
    logic             pin_is_input = 1'b0;
    logic             stat_clr_cap = 1'b0;
    logic             ctrl_wr = 1'b0;
    logic [CNT_W-1:0] cap_first, cap_second;
    logic             cap_event;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int stepn = 0;

    // Reference state, kept from the requirements.
    int               m_cnt = 0;
    logic             m_pin = 1'b0;
    logic [1:0]       m_mode = 2'd0;
    logic [CNT_W-1:0] m_c0 = '0, m_c1 = '0;
    logic             m_evt = 1'b0;

    edge_capture_unit #(.CNT_W(CNT_W)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [CNT_W-1:0] act,
                       input logic [CNT_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s step %0d: actual=%h expected=%h", tag, stepn, act, exp);
        end
    endtask

    // One clock: drive, update reference, sample after the edge.
    task automatic step(input logic p, input logic [1:0] m, input logic d,
                        input logic s, input logic clr, input logic cw,
                        input string tag);
        logic [CNT_W-1:0] cv;
        logic clear, hit;
        stepn++;
        cv = 32'h5A00_0000 + CNT_W'(stepn) * 32'd977;
        pin_in = p; cap_mode = m; pin_is_input = d; cnt_sel = s;
        stat_clr_cap = clr; ctrl_wr = cw; counter_in = cv;
        clear = clr | (cw && m_mode == 2'd0 && m != 2'd0);
        case (m)
            2'd1: hit = p & ~m_pin;
            2'd2: hit = ~p & m_pin;
            2'd3: hit = p ^ m_pin;
            default: hit = 1'b0;
        endcase
        m_evt = 1'b0;
        if (clear) m_cnt = 0;
        else if (hit && d && m_cnt < 2) begin
            if (m_cnt == 0) m_c0 = cv; else m_c1 = cv;
            m_evt = (m_cnt == int'(s));
            m_cnt++;
        end
        m_pin = p; m_mode = m;
        @(posedge clk); #1;
        stat_clr_cap = 1'b0; ctrl_wr = 1'b0;
        chk(tag, cap_first, m_c0);
        chk(tag, cap_second, m_c1);
        chk("R4", CNT_W'(cap_event), CNT_W'(m_evt));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R7", cap_first, '0);
        chk("R7", cap_second, '0);
        chk("R7", CNT_W'(cap_event), '0);
        rst_n = 1'b1;

        // Sweep every mode, direction and count select.
        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 2; s++) begin
                    string t;
                    t = (m == 0) ? "R1" : (d == 0) ? "R2" : "R3";
                    step(m_pin, 2'd0, d[0], s[0], 1'b0, 1'b1, "R6");
                    step(m_pin, 2'(m), d[0], s[0], 1'b0, 1'b1, "R6");
                    for (int k = 0; k < 6; k++)
                        step(~m_pin, 2'(m), d[0], s[0], 1'b0, 1'b0, t);
                    step(m_pin, 2'(m), d[0], s[0], 1'b1, 1'b0, "R5");
                    for (int k = 0; k < 3; k++)
                        step(~m_pin, 2'(m), d[0], s[0], 1'b0, 1'b0, "R5");
                end

        // R8: history follows the pin while off; no edge on enabling.
        step(1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        step(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        // R6: control write keeping mode active does not clear (count 1).
        step(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        step(1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        // R9: clear coinciding with an edge wins.
        step(1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        // R9: mode arm coinciding with an edge also wins.
        step(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule